// File: doc/BRIEF.md
# Packed rounding fixed-point multiplier

This block multiplies two packed vectors lane by lane, treating every lane as a signed Q15 number. Each lane pair produces a signed double-width product. The block rounds that product to the nearest Q15 value, with exact halves rounded upward, and keeps a lane-width result. The lane results are packed back into one vector in their original positions. With the default parameters the operands and the result are 128 bits wide, made of eight 16-bit lanes. Setting `LANES` to 4 gives a 64-bit variant.

An operand pair is accepted in any cycle where `in_valid_i` is high. The result appears two cycles later, qualified by `out_valid_o`. The first stage holds the products and the second holds the rounded and packed lanes. The result register loads only when a valid item reaches it, so `res_o` keeps the last result during idle cycles. Nothing saturates: the one lane pair that overflows wraps around.

Top module: `rnd_qmul`

## Requirements
- R1: Lane i uses bits [16i+15:16i] of each operand and of the result. A lane result depends only on lane i of `a_i` and lane i of `b_i`.
- R2: Every lane result is the low 16 bits of (a*b + 16384) >>> 15, where a and b are the signed lane values.
- R3: A lane value of 16384 scales the other operand by one half. For example, 124 times 16384 gives 62.
- R4: No saturation is applied. The pair 0x8000 times 0x8000 gives 0x8000.
- R5: Exact halves round toward plus infinity. (-1) times 16384 gives 0x0000, and 1 times 16384 gives 0x0001.
- R6: Swapping `a_i` and `b_i` gives an identical result.
- R7: `out_valid_o` equals `in_valid_i` from two cycles earlier. `res_o` changes only in a cycle where `out_valid_o` is high, and otherwise holds its value.
- R8: While `rst_ni` is low, `out_valid_o` is 0 and `res_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair valid |
| a_i | input | 128 | First packed operand |
| b_i | input | 128 | Second packed operand |
| out_valid_o | output | 1 | Result valid |
| res_o | output | 128 | Packed rounded result |

## Verification
The assertions check the following on every cycle:
- the two-cycle valid latency;
- that `res_o` holds its value while no result is valid;
- each lane's value against an independent rounding formula applied to the operands from two cycles back;
- the wrap of the overflow pair.

The bench's directed scenarios show the behaviours that only comparisons between transactions can reveal:
- operand swapping and the independence of each lane;
- the specific scaling and tie-rounding values;
- the extreme lane values;
- reset taken in the middle of a stream.

// File: rtl/qmul_pkg.sv
package qmul_pkg;
  parameter int unsigned QMUL_LANE_W = 16;
  parameter int unsigned QMUL_LANES  = 8;
endpackage

// File: rtl/qmul_lane_mul.sv
module qmul_lane_mul #(
  parameter int unsigned LANE_W = 16,
  localparam int unsigned PROD_W = 2 * LANE_W
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  output logic [PROD_W-1:0] prod_o
);
  logic signed [PROD_W-1:0] a_ext, b_ext;

  always_comb begin
    a_ext  = PROD_W'($signed(a_i));
    b_ext  = PROD_W'($signed(b_i));
    prod_o = a_ext * b_ext;
  end
endmodule

// File: rtl/qmul_lane_rnd.sv
module qmul_lane_rnd #(
  parameter int unsigned LANE_W = 16,
  localparam int unsigned PROD_W = 2 * LANE_W,
  localparam int unsigned PRE_SH = LANE_W - 2
) (
  input  logic [PROD_W-1:0] prod_i,
  output logic [LANE_W-1:0] res_o
);
  logic signed [PROD_W-1:0] shifted, bumped;

  // shift by W-2, add one, then drop bit 0: a hidden extra shift by one
  always_comb begin
    shifted = $signed(prod_i) >>> PRE_SH;
    bumped  = shifted + PROD_W'(1);
    res_o   = bumped[LANE_W:1];
  end
endmodule

// File: rtl/rnd_qmul.sv
module rnd_qmul
  import qmul_pkg::*;
#(
  parameter int unsigned LANE_W = QMUL_LANE_W,
  parameter int unsigned LANES  = QMUL_LANES,
  localparam int unsigned DATA_W = LANES * LANE_W,
  localparam int unsigned PROD_W = 2 * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] res_o
);
  logic [PROD_W-1:0] prod_d [LANES];
  logic [PROD_W-1:0] prod_q [LANES];
  logic [DATA_W-1:0] pack_d;
  logic [DATA_W-1:0] pack_q;
  logic              s1_valid_q, s2_valid_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    qmul_lane_mul #(.LANE_W(LANE_W)) u_mul (
      .a_i    (a_i[g*LANE_W +: LANE_W]),
      .b_i    (b_i[g*LANE_W +: LANE_W]),
      .prod_o (prod_d[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         prod_q[g] <= '0;
      else if (in_valid_i) prod_q[g] <= prod_d[g];
    end

    qmul_lane_rnd #(.LANE_W(LANE_W)) u_rnd (
      .prod_i (prod_q[g]),
      .res_o  (pack_d[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s2_valid_q <= 1'b0;
      pack_q     <= '0;
    end else begin
      s1_valid_q <= in_valid_i;
      s2_valid_q <= s1_valid_q;
      if (s1_valid_q) pack_q <= pack_d;
    end
  end

  assign out_valid_o = s2_valid_q;
  assign res_o       = pack_q;
endmodule

// File: rtl/rnd_qmul_chk.sv
module rnd_qmul_chk #(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned LANES  = 8,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] res_o
);
  localparam logic [LANE_W-1:0] MIN_V = {1'b1, {(LANE_W-1){1'b0}}};

  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               warm_q <= '0;
    else if (warm_q != 2'd3)   warm_q <= warm_q + 2'd1;
  end

  function automatic logic [LANE_W-1:0] mdl(logic [LANE_W-1:0] x, logic [LANE_W-1:0] y);
    logic signed [2*LANE_W:0] p;
    p = $signed(x) * $signed(y);
    p = p + (2*LANE_W+1)'(1 << (LANE_W-2));
    p = p >>> (LANE_W-1);
    return p[LANE_W-1:0];
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_reset_r8: assert (!out_valid_o && res_o == '0);
    end
  end

  p_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 2'd2) |-> (out_valid_o == $past(in_valid_i, 2)));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 2'd2 && !out_valid_o) |-> $stable(res_o));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    p_value_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q >= 2'd2 && out_valid_o) |->
        (res_o[g*LANE_W +: LANE_W] ==
         mdl($past(a_i[g*LANE_W +: LANE_W], 2), $past(b_i[g*LANE_W +: LANE_W], 2))));

    p_no_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q >= 2'd2 && out_valid_o &&
       $past(a_i[g*LANE_W +: LANE_W], 2) == MIN_V &&
       $past(b_i[g*LANE_W +: LANE_W], 2) == MIN_V) |->
        (res_o[g*LANE_W +: LANE_W] == MIN_V));
  end
endmodule

bind rnd_qmul rnd_qmul_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .a_i         (a_i),
  .b_i         (b_i),
  .out_valid_o (out_valid_o),
  .res_o       (res_o)
);

// File: tb/rnd_qmul_tb.sv
`timescale 1ns/1ps
module rnd_qmul_tb;
  localparam int LW = 16;
  localparam int NL = 8;
  localparam int DW = LW * NL;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid_i = 1'b0;
  logic [DW-1:0] a_i = '0, b_i = '0;
  logic          out_valid_o;
  logic [DW-1:0] res_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic          prev_v = 0;
  logic [DW-1:0] prev_r = '0;
  logic [DW-1:0] hold_r = '0;

  always #10 clk_i = ~clk_i;

  rnd_qmul u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
    .a_i(a_i), .b_i(b_i), .out_valid_o(out_valid_o), .res_o(res_o)
  );

  function automatic logic [LW-1:0] ref_lane(logic [LW-1:0] x, logic [LW-1:0] y);
    longint p;
    p = longint'($signed(x)) * longint'($signed(y));
    p = (p + 16384) >>> 15;
    return p[LW-1:0];
  endfunction

  function automatic logic [DW-1:0] ref_vec(logic [DW-1:0] x, logic [DW-1:0] y);
    logic [DW-1:0] r;
    for (int i = 0; i < NL; i++) r[i*LW +: LW] = ref_lane(x[i*LW +: LW], y[i*LW +: LW]);
    return r;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive, let the edge pass, compare against model
  task automatic cyc(logic v, logic [DW-1:0] a, logic [DW-1:0] b, string tag);
    in_valid_i = v; a_i = a; b_i = b;
    @(posedge clk_i);
    @(negedge clk_i);
    if (prev_v) hold_r = prev_r;
    chk({tag, " valid"}, DW'(out_valid_o), DW'(prev_v));
    chk({tag, " data"}, res_o, hold_r);
    prev_v = v;
    prev_r = ref_vec(a, b);
  endtask

  task automatic drain(string tag);
    cyc(1'b0, '0, '0, tag);
    cyc(1'b0, '0, '0, tag);
  endtask

  function automatic logic [DW-1:0] fill(logic [LW-1:0] v);
    return {NL{v}};
  endfunction

  logic [DW-1:0] ra, rb, r1;

  initial begin
    #2000000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R8 reset valid", DW'(out_valid_o), '0);
    chk("R8 reset data", res_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3: half scaling
    cyc(1'b1, fill(16'd124), fill(16'd16384), "R3");
    drain("R3");
    chk("R3 124x16384", DW'(res_o[15:0]), DW'(16'd62));

    // R5: ties toward plus infinity
    cyc(1'b1, {{4{16'hFFFF}}, {4{16'h0001}}}, fill(16'd16384), "R5");
    drain("R5");
    chk("R5 -1x16384", DW'(res_o[DW-1 -: LW]), DW'(16'h0000));
    chk("R5 1x16384", DW'(res_o[15:0]), DW'(16'h0001));

    // R4: wrap of the overflow pair
    cyc(1'b1, fill(16'h8000), fill(16'h8000), "R4");
    drain("R4");
    chk("R4 min x min", res_o, fill(16'h8000));

    // R1: lane independence, distinct lanes
    ra = '0; rb = '0;
    for (int i = 0; i < NL; i++) begin
      ra[i*LW +: LW] = LW'(1000 * (i + 1));
      rb[i*LW +: LW] = LW'(-3000 * i + 7);
    end
    cyc(1'b1, ra, rb, "R1");
    ra[3*LW +: LW] = 16'h7FFF;
    cyc(1'b1, ra, rb, "R1");
    drain("R1");

    // R2: extremes in all lanes
    begin
      logic [LW-1:0] ext [4] = '{16'h7FFF, 16'h8000, 16'hFFFF, 16'h0000};
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          cyc(1'b1, fill(ext[i]), fill(ext[j]), "R2 extreme");
      drain("R2 extreme");
    end

    // R6: commutation
    ra = {$urandom, $urandom, $urandom, $urandom};
    rb = {$urandom, $urandom, $urandom, $urandom};
    cyc(1'b1, ra, rb, "R6");
    drain("R6");
    r1 = res_o;
    cyc(1'b1, rb, ra, "R6");
    drain("R6");
    chk("R6 swap", res_o, r1);

    // R2/R7: random stream with bubbles
    for (int k = 0; k < 400; k++) begin
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      cyc(1'(($urandom % 3) != 0), ra, rb, "R2 R7 random");
    end
    drain("R7");

    // R8: reset in mid-stream
    cyc(1'b1, fill(16'h1234), fill(16'h4321), "R8");
    rst_ni = 1'b0;
    #3;
    chk("R8 async valid", DW'(out_valid_o), '0);
    chk("R8 async data", res_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    prev_v = 0; hold_r = '0;
    cyc(1'b1, fill(16'h4000), fill(16'h4000), "R8 restart");
    drain("R8 restart");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule